// File: doc/BRIEF.md
# Timer with capture-register TOP

A 16-bit synchronous up-counter that advances only on cycles where a tick enable, produced by a prescaler outside the block, is high. There are two modes. In free-running mode the counter wraps from 0xFFFF to 0x0000 and an external event copies the current count into the capture register. In clear-on-compare mode the same register holds the period limit (TOP): the counter returns to zero on the tick after it equals TOP.

Software reaches the counter and the TOP/capture register through a simple write port. The TOP register has no shadow copy, so a write takes effect on the next cycle. If the new TOP is lower than the current count, the counter misses the match, runs up through 0xFFFF, wraps, and only clears when it next reaches TOP. Two sticky flags, overflow and capture/TOP, each have a clear input and an interrupt enable.

Top module: `tcap_timer`

## Requirements
- R1: After reset the count, the capture/TOP register, both flags and both interrupt outputs are zero and the timer behaves as free-running.
- R2: When `tick_en` is low and no counter write is made, the count holds its value.
- R3: In free-running mode (`mode_ctc`=0) each tick adds one to the count, and a tick at 0xFFFF gives 0x0000.
- R4: The overflow flag is set by the tick that takes the count from 0xFFFF to 0x0000, in either mode.
- R5: In clear-on-compare mode (`mode_ctc`=1) a tick while the count equals the TOP register makes the next count 0x0000 and sets the capture/TOP flag.
- R6: A TOP write applies from the next cycle; a TOP below the current count is missed, so the counter runs through 0xFFFF, sets the overflow flag, and then clears at TOP.
- R7: In free-running mode, `cap_evt` high copies the count of that cycle into the capture register and sets the capture/TOP flag.
- R8: In clear-on-compare mode `cap_evt` changes neither the TOP register nor the capture/TOP flag.
- R9: A 1 on a flag's clear input clears it on the next cycle; if the flag is set in the same cycle, the set wins.
- R10: A counter write loads `wr_data` on the next cycle and overrides that cycle's tick, including its increment, clear and flag settings.
- R11: Each interrupt output is high exactly while its flag and its enable are both high.
- R12: A TOP/capture register write overrides a capture event in the same cycle, and the register takes `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer clock enable from prescaler |
| mode_ctc | input | 1 | 0 = free-running, 1 = clear-on-compare |
| wr_cnt_en | input | 1 | Write `wr_data` into the counter |
| wr_top_en | input | 1 | Write `wr_data` into the capture/TOP register |
| wr_data | input | 16 | Write data |
| cap_evt | input | 1 | External capture event (synchronous pulse) |
| ovf_clr | input | 1 | Clear overflow flag |
| capf_clr | input | 1 | Clear capture/TOP flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| capf_ie | input | 1 | Capture/TOP interrupt enable |
| count | output | 16 | Current count |
| cap_top | output | 16 | Capture/TOP register |
| ovf_flag | output | 1 | Overflow flag |
| cap_flag | output | 1 | Capture/TOP flag |
| ovf_irq | output | 1 | Overflow interrupt |
| cap_irq | output | 1 | Capture/TOP interrupt |

## Verification
A wrong count appears on `count` the cycle after the faulty tick and stays visible because every later value builds on it; the bench compares every cycle, so such an error shows within one cycle. A corrupted TOP value shows up as a clear at the wrong count, at worst one full 65536-tick lap later, which is why one missed-match run goes the whole way round. Flag faults show on the flag and interrupt pins in the cycle after the tick, event or clear that caused them.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    typedef enum logic {
        MODE_FREE = 1'b0,
        MODE_CTC  = 1'b1
    } tcap_mode_e;

    localparam int unsigned FLAG_N   = 2;
    localparam int unsigned FLAG_OVF = 0;
    localparam int unsigned FLAG_CAP = 1;

endpackage

// File: rtl/tcap_count.sv
module tcap_count
    import tcap_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  tcap_mode_e   mode,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         roll,
    output logic         top_hit
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    adv;

    always_comb begin
        st_d    = st_q;
        adv     = tick_en && !wr_en;
        roll    = adv && (st_q.cnt == CNT_MAX);
        top_hit = adv && (mode == MODE_CTC) && (st_q.cnt == top);
        if (wr_en) begin
            st_d.cnt = wr_data;
        end else if (adv) begin
            st_d.cnt = top_hit ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R2
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_en) |=> $stable(cnt));
    // R10
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt == $past(wr_data)));
    // R5
    ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_en && mode == MODE_CTC && cnt == top) |=> (cnt == '0));
    // R3
    free_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_en && mode == MODE_FREE) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/tcap_capreg.sv
module tcap_capreg
    import tcap_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tcap_mode_e   mode,
    input  logic         cap_evt,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cap,
    output logic         cap_hit
);
    typedef struct packed {
        logic [W-1:0] val;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        cap_hit = cap_evt && (mode == MODE_FREE);
        if (wr_en) begin
            st_d.val = wr_data;
        end else if (cap_hit) begin
            st_d.val = cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap = st_q.val;

    // R12
    top_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cap == $past(wr_data)));
    // R8
    ctc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CTC && !wr_en) |=> $stable(cap));
    // R7
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FREE && cap_evt && !wr_en) |=> (cap == $past(cnt)));
endmodule

// File: rtl/tcap_flags.sv
module tcap_flags
    import tcap_pkg::*;
#(
    parameter int unsigned N = FLAG_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ie,
    output logic [N-1:0] flag,
    output logic [N-1:0] irq
);
    typedef struct packed {
        logic [N-1:0] f;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            st_d.f[i] = set[i] | (st_q.f[i] & ~clr[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.f;

    for (genvar g = 0; g < N; g++) begin : g_flag
        assign irq[g] = flag[g] & ie[g];

        // R9
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> flag[g]);
        // R9
        clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !set[g]) |=> !flag[g]);
        // R9
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[g] && !set[g]) |=> $stable(flag[g]));
    end
endmodule

// File: rtl/tcap_timer.sv
module tcap_timer
    import tcap_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             mode_ctc,
    input  logic             wr_cnt_en,
    input  logic             wr_top_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cap_evt,
    input  logic             ovf_clr,
    input  logic             capf_clr,
    input  logic             ovf_ie,
    input  logic             capf_ie,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_top,
    output logic             ovf_flag,
    output logic             cap_flag,
    output logic             ovf_irq,
    output logic             cap_irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    tcap_mode_e         mode;
    logic               roll, top_hit, cap_hit;
    logic [FLAG_N-1:0]  f_set, f_clr, f_ie, f_q, f_irq;

    assign mode = tcap_mode_e'(mode_ctc);

    tcap_count #(.W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .mode    (mode),
        .wr_en   (wr_cnt_en),
        .wr_data (wr_data),
        .top     (cap_top),
        .cnt     (count),
        .roll    (roll),
        .top_hit (top_hit)
    );

    tcap_capreg #(.W(CNT_W)) u_capreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .cap_evt (cap_evt),
        .wr_en   (wr_top_en),
        .wr_data (wr_data),
        .cnt     (count),
        .cap     (cap_top),
        .cap_hit (cap_hit)
    );

    always_comb begin
        f_set           = '0;
        f_clr           = '0;
        f_ie            = '0;
        f_set[FLAG_OVF] = roll;
        f_set[FLAG_CAP] = top_hit | cap_hit;
        f_clr[FLAG_OVF] = ovf_clr;
        f_clr[FLAG_CAP] = capf_clr;
        f_ie[FLAG_OVF]  = ovf_ie;
        f_ie[FLAG_CAP]  = capf_ie;
    end

    tcap_flags #(.N(FLAG_N)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (f_set),
        .clr   (f_clr),
        .ie    (f_ie),
        .flag  (f_q),
        .irq   (f_irq)
    );

    assign ovf_flag = f_q[FLAG_OVF];
    assign cap_flag = f_q[FLAG_CAP];
    assign ovf_irq  = f_irq[FLAG_OVF];
    assign cap_irq  = f_irq[FLAG_CAP];

    // R4
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_cnt_en && count == CNT_MAX) |=> (ovf_flag && count == '0));
    // R5
    top_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_cnt_en && mode_ctc && count == cap_top) |=> cap_flag);
    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && cap_top == '0 && !ovf_flag && !cap_flag));
endmodule

// File: tb/tb_tcap_timer.sv
module tb_tcap_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, mode_ctc = 1'b0, wr_cnt_en = 1'b0, wr_top_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        cap_evt = 1'b0, ovf_clr = 1'b0, capf_clr = 1'b0;
    logic        ovf_ie = 1'b0, capf_ie = 1'b0;
    logic [15:0] count, cap_top;
    logic        ovf_flag, cap_flag, ovf_irq, cap_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] m_cnt = '0, m_top = '0;
    logic        m_ovf = 1'b0, m_capf = 1'b0;

    always #4 clk = ~clk;

    tcap_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_ctc(mode_ctc),
        .wr_cnt_en(wr_cnt_en), .wr_top_en(wr_top_en), .wr_data(wr_data),
        .cap_evt(cap_evt), .ovf_clr(ovf_clr), .capf_clr(capf_clr),
        .ovf_ie(ovf_ie), .capf_ie(capf_ie), .count(count), .cap_top(cap_top),
        .ovf_flag(ovf_flag), .cap_flag(cap_flag), .ovf_irq(ovf_irq), .cap_irq(cap_irq)
    );

    function automatic logic [15:0] exp_cnt(logic [15:0] c, logic [15:0] t, logic tk,
                                            logic ctc, logic wc, logic [15:0] d);
        if (wc)               return d;
        if (!tk)              return c;
        if (ctc && c == t)    return 16'h0000;
        return c + 16'd1;
    endfunction

    function automatic logic [15:0] exp_top(logic [15:0] c, logic [15:0] t, logic ctc,
                                            logic wt, logic ev, logic [15:0] d);
        if (wt)         return d;
        if (!ctc && ev) return c;
        return t;
    endfunction

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "count",    count,            m_cnt);
        chk(tag, "cap_top",  cap_top,          m_top);
        chk(tag, "ovf_flag", {15'd0, ovf_flag}, {15'd0, m_ovf});
        chk(tag, "cap_flag", {15'd0, cap_flag}, {15'd0, m_capf});
        chk(tag, "ovf_irq",  {15'd0, ovf_irq},  {15'd0, m_ovf & ovf_ie});
        chk(tag, "cap_irq",  {15'd0, cap_irq},  {15'd0, m_capf & capf_ie});
    endtask

    task automatic step(string tag, logic tk, logic ctc, logic wc, logic wt,
                        logic [15:0] d, logic ev, logic oc, logic cc);
        logic        adv, s_ovf, s_cap;
        logic [15:0] n_cnt, n_top;
        tick_en = tk; mode_ctc = ctc; wr_cnt_en = wc; wr_top_en = wt;
        wr_data = d; cap_evt = ev; ovf_clr = oc; capf_clr = cc;
        adv   = tk && !wc;
        s_ovf = adv && (m_cnt == 16'hFFFF);
        s_cap = (adv && ctc && m_cnt == m_top) || (!ctc && ev);
        n_cnt = exp_cnt(m_cnt, m_top, tk, ctc, wc, d);
        n_top = exp_top(m_cnt, m_top, ctc, wt, ev, d);
        @(posedge clk);
        #1;
        m_cnt  = n_cnt;
        m_top  = n_top;
        m_ovf  = s_ovf | (m_ovf & ~oc);
        m_capf = s_cap | (m_capf & ~cc);
        compare_all(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        compare_all("R1");
        rst_n = 1'b1;

        // R10: counter write beats a tick
        step("R10", 1, 0, 1, 0, 16'h0005, 0, 0, 0);
        // R2: hold without tick
        repeat (3) step("R2", 0, 0, 0, 0, 16'h1234, 0, 0, 0);

        // R3 and R4: wrap in free-running mode
        step("R10", 0, 0, 1, 0, 16'hFFFE, 0, 0, 0);
        step("R3", 1, 0, 0, 0, 16'h0, 0, 0, 0);
        step("R4", 1, 0, 0, 0, 16'h0, 0, 0, 0);
        chk("R4", "ovf after wrap", {15'd0, ovf_flag}, 16'd1);

        // R11: interrupt follows enable
        ovf_ie = 1'b1; #1;
        chk("R11", "ovf_irq enabled", {15'd0, ovf_irq}, 16'd1);
        ovf_ie = 1'b0; #1;
        chk("R11", "ovf_irq disabled", {15'd0, ovf_irq}, 16'd0);

        // R9: clear, then set wins over clear
        step("R9", 0, 0, 0, 0, 16'h0, 0, 1, 0);
        chk("R9", "ovf cleared", {15'd0, ovf_flag}, 16'd0);
        step("R9", 0, 0, 1, 0, 16'hFFFF, 0, 0, 0);
        step("R9", 1, 0, 0, 0, 16'h0, 0, 1, 0);
        chk("R9", "set wins", {15'd0, ovf_flag}, 16'd1);
        step("R9", 0, 0, 0, 0, 16'h0, 0, 1, 0);

        // R5: clear-on-compare with TOP = 3
        step("R5", 0, 1, 1, 1, 16'h0000, 0, 0, 0);
        step("R5", 0, 1, 0, 1, 16'h0003, 0, 0, 0);
        repeat (3) step("R5", 1, 1, 0, 0, 16'h0, 0, 0, 0);
        chk("R5", "count at TOP", count, 16'h0003);
        step("R5", 1, 1, 0, 0, 16'h0, 0, 0, 0);
        chk("R5", "count cleared", count, 16'h0000);
        chk("R5", "top flag", {15'd0, cap_flag}, 16'd1);
        step("R5", 0, 1, 0, 0, 16'h0, 0, 0, 1);

        // R8: capture event ignored in clear-on-compare mode
        step("R8", 1, 1, 0, 0, 16'h0, 1, 0, 0);
        chk("R8", "TOP kept", cap_top, 16'h0003);
        chk("R8", "no flag", {15'd0, cap_flag}, 16'd0);

        // R6: missed match runs through 0xFFFF
        step("R6", 0, 1, 0, 1, 16'd20, 0, 0, 0);
        step("R6", 0, 1, 1, 0, 16'd10, 0, 0, 0);
        step("R6", 0, 1, 0, 1, 16'd5, 0, 0, 0);
        while (count != 16'hFFFF && !done) step("R6", 1, 1, 0, 0, 16'h0, 0, 0, 0);
        chk("R6", "no early clear flag", {15'd0, cap_flag}, 16'd0);
        step("R6", 1, 1, 0, 0, 16'h0, 0, 0, 0);
        chk("R6", "wrap sets ovf", {15'd0, ovf_flag}, 16'd1);
        repeat (6) step("R6", 1, 1, 0, 0, 16'h0, 0, 0, 0);
        chk("R6", "clear at new TOP", count, 16'h0000);
        chk("R6", "top flag", {15'd0, cap_flag}, 16'd1);
        step("R6", 0, 0, 0, 0, 16'h0, 0, 1, 1);

        // R7: capture in free-running mode
        step("R7", 0, 0, 1, 0, 16'd100, 0, 0, 0);
        capf_ie = 1'b1;
        step("R7", 1, 0, 0, 0, 16'h0, 1, 0, 0);
        chk("R7", "captured count", cap_top, 16'd100);
        chk("R11", "cap_irq", {15'd0, cap_irq}, 16'd1);

        // R12: register write beats capture
        step("R12", 1, 0, 0, 1, 16'hABCD, 1, 0, 1);
        chk("R12", "write wins", cap_top, 16'hABCD);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic r_ctc;
            r_ctc = (($urandom % 3) == 0);
            step("R3/R4/R5/R7/R9", ($urandom % 4) != 0, r_ctc,
                 ($urandom % 40) == 0, ($urandom % 50) == 0,
                 r_ctc ? 16'($urandom % 64) : 16'($urandom),
                 ($urandom % 15) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0);
            if (($urandom % 100) == 0) begin
                ovf_ie  = ~ovf_ie;
                capf_ie = ~capf_ie;
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule